// File: doc/BRIEF.md
# Serial-Load Register with Latched Parallel Bus Outputs

This block turns a serial bit stream into an eight-bit parallel word. Bits enter a chain of shift flops on each rising clock edge. A level-sensitive capture stage copies the chain into a holding word while the strobe input is high and freezes that word when strobe drops. The holding word drives a parallel bus that releases to high impedance when the output enable is low. A separate drive-enable output lets a tri-state-free build place a multiplexer at the bus instead.

The last flop of the chain leaves the block on two serial outputs for chaining several blocks. One output follows the rising edge. The other repeats the same bit half a cycle later, on the falling edge, so a downstream block with slow clock edges still sees a stable bit. An asynchronous active-low reset clears the chain, the holding word and both serial outputs. The reset is released in step with the clock.

Top module: `ssr_bus_reg`

## Requirements
- R1: After reset is released, the holding word, the parallel outputs (enable high) and both serial outputs read all zeros until new bits are shifted in.
- R2: On every rising edge the serial input enters stage 0 and each stage k takes the old value of stage k-1. Parallel bit i (par_q[i]) reflects stage i.
- R3: While strobe is high the holding word follows the chain. When strobe is still high across a rising edge, the parallel outputs show the newly shifted word in the same cycle.
- R4: While strobe is low the holding word keeps its value, whatever is shifted in.
- R5: With oe high, par_en is 1 and par_q equals the holding word. With oe low, par_en is 0 and par_q is released to high impedance.
- R6: ser_q_rise shows stage 7 and changes only on the rising edge. The first of eight bits shifted in appears there after the eighth rising edge.
- R7: ser_q_fall carries the value of ser_q_rise, taken on the falling edge that follows each rising edge, so it lags by half a clock.
- R8: Strobe and oe have no effect on either serial output.
- R9: With ser_q_fall of one block feeding ser_in of a second, the pair acts as a 16-stage chain: the second block's ser_q_rise shows the input bit from 16 rising edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; rising edge shifts, falling edge retimes the cascade bit |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_in | input | 1 | Serial data into stage 0 |
| strobe | input | 1 | High: holding word follows the chain; low: holds |
| oe | input | 1 | Parallel output enable, active high |
| par_q | output | 8 | Parallel outputs from the holding word, high impedance when oe is low |
| par_en | output | 1 | Drive enable for the parallel bus |
| ser_q_rise | output | 1 | Stage 7, rising-edge timed |
| ser_q_fall | output | 1 | Stage 7, retimed to the falling edge |

## Verification
A wrong chain bit reaches ser_q_rise within at most eight rising edges. If strobe is high, it reaches the parallel outputs in the same cycle. A holding word that leaks while strobe is low shows up on the next enabled parallel sample. A falling-edge output that is off by an edge shows up as a mismatch before the next rising edge. The cascaded pair shows any such fault again at the second block's outputs, sixteen edges behind the input.

// File: rtl/ssr_pkg.sv
`timescale 1ns/1ps
package ssr_pkg;
  // default chain length and reset synchronizer depth
  localparam int unsigned SSR_STAGES    = 8;
  localparam int unsigned SSR_SYNC_FLOP = 2;
endpackage

// File: rtl/ssr_rst_sync.sv
`timescale 1ns/1ps
// asynchronous assert, synchronous release of the active-low reset
module ssr_rst_sync #(
  parameter int unsigned DEPTH = ssr_pkg::SSR_SYNC_FLOP
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [DEPTH-1:0] sync_q;
  logic [DEPTH-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q = sync_q[DEPTH-1];
endmodule

// File: rtl/ssr_shift_chain.sv
`timescale 1ns/1ps
// serial-in chain: stage 0 takes the input, stage k takes stage k-1
module ssr_shift_chain #(
  parameter int unsigned STAGES = ssr_pkg::SSR_STAGES
) (
  input  logic              clk,
  input  logic              rst_q,
  input  logic              din,
  output logic [STAGES-1:0] stage_q
);
  logic [STAGES-1:0] stage_d;

  assign stage_d[0] = din;
  for (genvar k = 1; k < STAGES; k++) begin : g_link
    assign stage_d[k] = stage_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) stage_q <= '0;
    else        stage_q <= stage_d;
  end
endmodule

// File: rtl/ssr_store_latch.sv
`timescale 1ns/1ps
// level-sensitive holding word: transparent while strobe is high
module ssr_store_latch #(
  parameter int unsigned STAGES = ssr_pkg::SSR_STAGES
) (
  input  logic              rst_q,
  input  logic              strobe,
  input  logic [STAGES-1:0] din,
  output logic [STAGES-1:0] hold_q
);
  always_latch begin
    if (!rst_q)      hold_q <= '0;
    else if (strobe) hold_q <= din;
  end
endmodule

// File: rtl/ssr_fall_retime.sv
`timescale 1ns/1ps
// repeats the cascade bit on the falling clock edge
module ssr_fall_retime (
  input  logic clk,
  input  logic rst_q,
  input  logic din,
  output logic dout
);
  logic nxt;

  always_comb begin
    nxt = din;
  end

  always_ff @(negedge clk or negedge rst_q) begin
    if (!rst_q) dout <= 1'b0;
    else        dout <= nxt;
  end
endmodule

// File: rtl/ssr_bus_reg.sv
`timescale 1ns/1ps
module ssr_bus_reg #(
  parameter int unsigned STAGES       = ssr_pkg::SSR_STAGES,
  parameter bit          USE_TRISTATE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  input  logic              strobe,
  input  logic              oe,
  output logic [STAGES-1:0] par_q,
  output logic              par_en,
  output logic              ser_q_rise,
  output logic              ser_q_fall
);
  localparam int unsigned LAST = STAGES - 1;

  logic              rst_q;
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] store_q;

  ssr_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  ssr_shift_chain #(.STAGES(STAGES)) u_chain (
    .clk     (clk),
    .rst_q   (rst_q),
    .din     (ser_in),
    .stage_q (shift_q)
  );

  ssr_store_latch #(.STAGES(STAGES)) u_store (
    .rst_q  (rst_q),
    .strobe (strobe),
    .din    (shift_q),
    .hold_q (store_q)
  );

  assign ser_q_rise = shift_q[LAST];

  ssr_fall_retime u_fall (
    .clk   (clk),
    .rst_q (rst_q),
    .din   (shift_q[LAST]),
    .dout  (ser_q_fall)
  );

  assign par_en = oe;

  if (USE_TRISTATE) begin : g_tri
    assign par_q = oe ? store_q : {STAGES{1'bz}};
  end else begin : g_mux
    assign par_q = store_q;
  end
endmodule

// File: rtl/ssr_bus_reg_chk.sv
`timescale 1ns/1ps
module ssr_bus_reg_chk #(
  parameter int unsigned STAGES = ssr_pkg::SSR_STAGES
) (
  input logic              clk,
  input logic              rst_q,
  input logic              ser_in,
  input logic              strobe,
  input logic              oe,
  input logic [STAGES-1:0] shift_q,
  input logic [STAGES-1:0] store_q,
  input logic [STAGES-1:0] par_q,
  input logic              par_en,
  input logic              ser_q_rise,
  input logic              ser_q_fall
);
  // R2: entry and one-step move of the chain
  a_r2_shift_step: assert property (@(posedge clk) disable iff (!rst_q)
    $past(rst_q) |-> (shift_q[0] == $past(ser_in)) &&
                     (shift_q[STAGES-1:1] == $past(shift_q[STAGES-2:0])));

  // R3: transparent holding word
  a_r3_follow: assert property (@(negedge clk) disable iff (!rst_q)
    strobe |-> store_q == shift_q);

  // R4: holding word frozen while strobe stays low
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_q)
    ($past(rst_q) && !strobe && !$past(strobe)) |-> $stable(store_q));

  // R5: enabled bus shows the holding word
  a_r5_drive: assert property (@(negedge clk) disable iff (!rst_q)
    oe |-> (par_en && par_q == store_q));

  // R6: rising-edge serial output is the former stage 6
  a_r6_serial_end: assert property (@(posedge clk) disable iff (!rst_q)
    $past(rst_q) |-> ser_q_rise == $past(shift_q[STAGES-2]));

  // R7: falling-edge output has caught up before the next rising edge
  a_r7_fall_copy: assert property (@(posedge clk) disable iff (!rst_q)
    $past(rst_q) |-> ser_q_fall == ser_q_rise);
endmodule

bind ssr_bus_reg ssr_bus_reg_chk #(.STAGES(STAGES)) u_chk (
  .clk        (clk),
  .rst_q      (rst_q),
  .ser_in     (ser_in),
  .strobe     (strobe),
  .oe         (oe),
  .shift_q    (shift_q),
  .store_q    (store_q),
  .par_q      (par_q),
  .par_en     (par_en),
  .ser_q_rise (ser_q_rise),
  .ser_q_fall (ser_q_fall)
);

// File: tb/sim_ssr_bus_reg.sv
`timescale 1ns/1ps
module sim_ssr_bus_reg;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_in = 1'b0;
  logic strobe = 1'b0;
  logic oe = 1'b1;

  logic [N-1:0] a_par, b_par;
  logic a_en, b_en, a_rise, b_rise, a_fall, b_fall;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model: chain and holding word of each block
  logic [N-1:0] m0 = '0, m1 = '0, h0 = '0, h1 = '0;

  always #4 clk = ~clk;

  ssr_bus_reg u0 (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .strobe(strobe), .oe(oe),
    .par_q(a_par), .par_en(a_en), .ser_q_rise(a_rise), .ser_q_fall(a_fall)
  );

  ssr_bus_reg u1 (
    .clk(clk), .rst_n(rst_n), .ser_in(a_fall), .strobe(strobe), .oe(oe),
    .par_q(b_par), .par_en(b_en), .ser_q_rise(b_rise), .ser_q_fall(b_fall)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] shift_in(input logic [N-1:0] v, input logic b);
    return {v[N-2:0], b};
  endfunction

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // one clock: check falling-edge outputs, drive, then check after the rising edge
  task automatic step(input logic d, input logic s, input logic o, input string ptag);
    logic old0, old1;
    @(negedge clk); #1;
    chk("R7 u0 fall", a_fall, m0[N-1]);
    chk("R9 u1 fall", b_fall, m1[N-1]);
    old0 = m0[N-1];
    old1 = m1[N-1];
    ser_in = d; strobe = s; oe = o;
    @(posedge clk); #2;
    m1 = shift_in(m1, old0);
    m0 = shift_in(m0, d);
    if (s) begin h0 = m0; h1 = m1; end
    if (o) begin
      chk({ptag, " u0 par"}, a_par, h0);
      chk({ptag, " u1 par"}, b_par, h1);
      chk("R5 en high", a_en, 1'b1);
    end else begin
      chk("R5 en low", {a_en, b_en}, 2'b00);
    end
    chk("R6 R8 u0 rise", a_rise, m0[N-1]);
    chk("R9 u1 rise", b_rise, m1[N-1]);
    chk("R7 fall lags", a_fall, old0);
    chk("R9 u1 fall lags", b_fall, old1);
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1: reset state
    chk("R1 par", a_par, '0);
    chk("R1 rise/fall", {a_rise, a_fall, b_rise, b_fall}, 4'b0);
    chk("R1 en", a_en, 1'b1);

    // R2/R3: walking one with strobe held high, visible same cycle
    step(1'b1, 1'b1, 1'b1, "R2");
    for (int k = 1; k < N; k++) begin
      step(1'b0, 1'b1, 1'b1, "R3");
      chk("R2 walking one", a_par, 32'(1) << k);
    end
    // R6: first bit of eight now at the serial end
    chk("R6 first in", a_rise, 1'b1);

    // R4: shift a pattern with strobe low, holding word must not move
    for (int k = 0; k < N; k++) step(1'b1, 1'b0, 1'b1, "R4");
    chk("R4 held", a_par, 32'h80);
    step(1'b0, 1'b1, 1'b1, "R3");
    chk("R3 load", a_par, 32'hFE);

    // R5/R8: bus released while shifting continues
    for (int k = 0; k < 4; k++) step(k[0], 1'b1, 1'b0, "R5");

    // R9: constrained random traffic through the cascade
    for (int k = 0; k < 400; k++) begin
      logic d, s, o;
      d = 1'($urandom % 2);
      s = (($urandom % 4) == 0);
      o = (($urandom % 4) != 0);
      step(d, s, o, s ? "R3" : "R4");
    end
    report();
  end
endmodule